// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a register-driven management master for clause 22 PHY access. Software first loads a 16-bit data register. It then writes a command word that carries a go/busy flag, a read/write select, the PHY address, the PHY register address and a two-bit clock-rate select. The block divides the system clock down to MDC, shifts one complete management frame onto MDIO and controls the MDIO output enable. It clears the busy flag when the frame is over.

For a read, the block releases the MDIO line for the turnaround and the data field. It collects the 16 bits that the PHY returns and places them in the data register. The data register is valid as soon as busy reads back clear. A command write that arrives while a frame is in flight is dropped. Software therefore polls busy before it issues the next command.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command readback is zero, so busy is clear, MDC is low and the MDIO output enable is low.
- R2: A write with `wr_cmd_i`=1 stores the word in the command register; `wr_cmd_i`=0 loads bits 15:0 into the data register. Command bit 0 is busy/go. Setting it starts a frame, and the hardware clears it after the frame's last MDC period. A command word with bit 0 clear is stored but starts no frame, and MDC stays low.
- R3: With command bit 1 set (write), the frame sent MSB-first is: 32 ones, start 01, opcode 01, PHY address (command bits 16:12), register address (command bits 8:4), turnaround 10, then the 16 data-register bits. The output enable is high for all 64 bits.
- R4: With command bit 1 clear (read), the opcode is 10. The output enable is high for the first 46 bits and low for the 2 turnaround bits and the 16 data bits. `mdio_i` is sampled at each rising MDC edge of the data field, MSB first, and the value appears on `data_o` once busy is clear.
- R5: Command bits 21:20 set the MDC period: 0, 1, 2 and 3 give 16, 32, 64 and 128 system clocks, each with a 50% duty cycle.
- R6: During a frame, `mdio_o` changes only on a falling edge of MDC.
- R7: A command write while busy is set changes neither the command register nor the frame in progress.
- R8: MDC is low whenever no frame is in progress, and each frame lasts exactly 64 MDC periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_cmd_i | input | 1 | 1 selects the command register, 0 the data register |
| wr_data_i | input | 32 | Write data |
| cmd_o | output | 32 | Command register readback, bit 0 is busy |
| data_o | output | 16 | Data register readback |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to reach from the ports is the read data field. The line is released and the captured bits must line up with MDC rising edges that the bench does not drive. The bench therefore acts as a PHY: it counts MDC rising edges and presents each response bit on the preceding MDC falling edge, so every bit is stable for half a period around the sample point. Dropped commands are covered by writing a different command word partway through a frame. The bench then checks both the readback and the full frame as it appeared on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUSY_BIT  = 0;
  localparam int WR_BIT    = 1;
  localparam int REG_LSB   = 4;
  localparam int PHY_LSB   = 12;
  localparam int DIV_LSB   = 20;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int DIV_W     = 2;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS  = TA_POS + 2;

  function automatic logic [FRAME_LEN-1:0] build_frame(
      input logic              is_wr,
      input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regad,
      input logic [DATA_W-1:0] wdata);
    logic [1:0] op;
    logic [DATA_W+1:0] tail;
    op   = is_wr ? 2'b01 : 2'b10;
    tail = is_wr ? {2'b10, wdata} : '1;
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, regad, tail};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int BASE_HALF = 8,
  parameter int SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF) + 1;

  logic [CNT_W-1:0] cnt_q, half_m1;
  logic             mdc_q, wrap;

  assign half_m1 = (CNT_W'(BASE_HALF) << div_sel_i) - CNT_W'(1);
  assign wrap    = run_i && (cnt_q == half_m1);
  assign rise_o  = wrap && !mdc_q;
  assign fall_o  = wrap && mdc_q;
  assign mdc_o   = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_wr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] sh_q;
  logic [IDX_W-1:0]     bit_q;
  logic                 active_q, done_q, wr_q;
  logic [DATA_W-1:0]    rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '1;
      bit_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
      rd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        sh_q     <= build_frame(is_wr_i, phy_i, reg_i, wdata_i);
        bit_q    <= '0;
        wr_q     <= is_wr_i;
        active_q <= 1'b1;
      end else if (active_q) begin
        // sample on rising MDC, advance on falling MDC
        if (rise_i && !wr_q && bit_q >= IDX_W'(DATA_POS))
          rd_q <= {rd_q[DATA_W-2:0], mdio_i};
        if (fall_i) begin
          if (bit_q == IDX_W'(FRAME_LEN - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + IDX_W'(1);
            sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
          end
        end
      end
    end
  end

  assign active_o  = active_q;
  assign done_o    = done_q;
  assign mdio_o    = sh_q[FRAME_LEN-1];
  assign mdio_oe_o = active_q && (wr_q || bit_q < IDX_W'(TA_POS));
  assign rdata_o   = rd_q;

  p_mdio_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(active_q) && active_q && !$stable(mdio_o) |-> $past(fall_i));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_cmd_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] cmd_o,
  output logic [15:0] data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [31:0]       cmd_q;
  logic [DATA_W-1:0] data_q, rdata;
  logic              busy, wr_cmd, start, active, done, rise, fall;

  assign busy   = cmd_q[BUSY_BIT];
  assign wr_cmd = wr_en_i && wr_cmd_i && !busy;
  assign start  = wr_cmd && wr_data_i[BUSY_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= wr_data_i;
      else if (done) cmd_q[BUSY_BIT] <= 1'b0;
      if (done && !cmd_q[WR_BIT]) data_q <= rdata;
      else if (wr_en_i && !wr_cmd_i) data_q <= wr_data_i[DATA_W-1:0];
    end
  end

  mdio_mdc_gen #(.BASE_HALF(8), .SEL_W(DIV_W)) u_mdc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active),
    .div_sel_i (cmd_q[DIV_LSB +: DIV_W]),
    .mdc_o     (mdc_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  mdio_frame_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .is_wr_i   (wr_data_i[WR_BIT]),
    .phy_i     (wr_data_i[PHY_LSB +: ADDR_W]),
    .reg_i     (wr_data_i[REG_LSB +: ADDR_W]),
    .wdata_i   (data_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (active),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rdata_o   (rdata)
  );

  assign cmd_o  = cmd_q;
  assign data_o = data_q;

  p_mdc_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  p_busy_cover_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> busy);
  p_done_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy);
  p_cmd_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done && wr_en_i && wr_cmd_i |=> $stable(cmd_q));
  p_oe_off_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o);
endmodule

// File: tb/mdio_cmd_engine_bench.sv
`timescale 1ns/1ps
module mdio_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_cmd = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] cmd;
  logic [15:0] data;
  logic        mdc, mdio, mdio_oe;
  logic        mdio_in = 1'b1;

  int vectors = 0, errors = 0;
  logic [63:0] frame, oe_frame;
  logic [15:0] resp = '0;
  int          nrise = 0;
  realtime     last_rise = 0.0, period = 0.0;

  always #2.5 clk = ~clk;

  mdio_cmd_engine u_mdio_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
    .wr_data_i(wr_data), .cmd_o(cmd), .data_o(data), .mdc_o(mdc),
    .mdio_o(mdio), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model: record on MDC rise, answer on MDC fall
  always @(posedge mdc) begin
    #1;
    frame    = {frame[62:0], mdio};
    oe_frame = {oe_frame[62:0], mdio_oe};
    if (nrise > 0) period = $realtime - last_rise;
    last_rise = $realtime;
    nrise++;
  end
  always @(negedge mdc) begin
    if (nrise >= 48 && nrise < 64) mdio_in = resp[63-nrise];
    else mdio_in = 1'b1;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic is_cmd, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = is_cmd; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(logic wr, logic [4:0] phy, logic [4:0] ra, logic [1:0] sel);
    return (32'(sel) << 20) | (32'(phy) << 12) | (32'(ra) << 4) | (32'(wr) << 1) | 32'h1;
  endfunction

  task automatic wait_idle();
    while (cmd[0]) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 cmd", 64'(cmd), 64'h0);
    check("R1 mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  task automatic t_write(logic [4:0] phy, logic [4:0] ra, logic [15:0] d, logic [1:0] sel);
    reg_wr(1'b0, {16'h0, d});
    check("R2 data reg", 64'(data), 64'(d));
    nrise = 0;
    reg_wr(1'b1, mk_cmd(1'b1, phy, ra, sel));
    check("R2 busy set", 64'(cmd[0]), 64'h1);
    wait_idle();
    check("R3 write frame", frame, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, d});
    check("R3 oe", oe_frame, '1);
    check("R5 period", 64'(longint'(period)), 64'(longint'(5 * (16 << sel))));
    check("R8 periods", 64'(nrise), 64'd64);
    check("R8 mdc idle", {63'h0, mdc}, 64'h0);
  endtask

  task automatic t_read(logic [4:0] phy, logic [4:0] ra, logic [15:0] r, logic [1:0] sel);
    resp = r;
    nrise = 0;
    reg_wr(1'b1, mk_cmd(1'b0, phy, ra, sel));
    wait_idle();
    check("R4 read header", 64'(frame[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra}));
    check("R4 oe", oe_frame, {{46{1'b1}}, 18'h0});
    check("R4 read data", 64'(data), 64'(r));
    check("R5 period", 64'(longint'(period)), 64'(longint'(5 * (16 << sel))));
    check("R2 busy clear", 64'(cmd[0]), 64'h0);
  endtask

  task automatic t_no_go();
    logic [31:0] c;
    c = mk_cmd(1'b1, 5'h3, 5'h4, 2'd0) & ~32'h1;
    nrise = 0;
    reg_wr(1'b1, c);
    repeat (100) @(negedge clk);
    check("R2 stored no go", 64'(cmd), 64'(c));
    check("R2 no mdc", 64'(nrise), 64'h0);
  endtask

  task automatic t_ignore();
    logic [31:0] c;
    reg_wr(1'b0, 32'h0000_5AA5);
    c = mk_cmd(1'b1, 5'h11, 5'h0A, 2'd0);
    nrise = 0;
    reg_wr(1'b1, c);
    repeat (200) @(negedge clk);
    reg_wr(1'b1, mk_cmd(1'b0, 5'h02, 5'h1F, 2'd3));
    check("R7 cmd kept", 64'(cmd), 64'(c));
    wait_idle();
    check("R7 frame kept", frame, {32'hFFFF_FFFF, 4'b0101, 5'h11, 5'h0A, 2'b10, 16'h5AA5});
    check("R7 period kept", 64'(longint'(period)), 64'd80);
  endtask

  initial begin
    #(5 * 180000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(5'h01, 5'h00, 16'h8140, 2'd0);
    t_write(5'h1E, 5'h15, 16'h3C0F, 2'd1);
    t_read(5'h05, 5'h02, 16'hA55A, 2'd0);
    t_read(5'h1F, 5'h1F, 16'h8001, 2'd2);
    t_read(5'h0A, 5'h11, 16'h7FFE, 2'd3);
    t_no_go();
    t_ignore();
    t_write(5'h00, 5'h1F, 16'hFFFF, 2'd2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule